// File: doc/BRIEF.md
# Block-Buffered Pseudo-DMA Data Engine

This engine moves bytes between a host byte port and an 8-bit SCSI data bus that uses a REQ/ACK handshake. Data passes through one shared buffer of `BLK_BYTES` bytes, which is 128 by default. The host owns the buffer and the SCSI side waits, or the reverse. A not-ready flag decides who owns the buffer, and its meaning depends on the direction.

- **Send:** the host fills the buffer and the SCSI side drains it.
- **Receive:** the SCSI side fills the buffer and the host empties it.

An 8-bit block counter is loaded by the host. The engine decrements it after each block that crosses the SCSI side. When the counter reaches zero, the engine disarms itself and raises an end-of-transfer flag. In send mode it also raises a last-byte-sent flag. It can optionally raise an interrupt.

If the target releases BSY while busy monitoring is enabled, the engine abandons the transfer. REQ and BSY each pass through a two-flop synchronizer before the engine uses them.

Top module: `pdma_block_engine`

## Requirements
- R1: Reset puts the engine in this state:
  - direction send, not-ready 0, busy 0;
  - block count 0, disarmed;
  - end, last-sent and interrupt flags 0;
  - ACK low;
  - host pointer at the end of the buffer, so host reads return 0xFF and host writes are dropped.
- R2: The direction input is 0 for send and 1 for receive.
  - A direction write that changes the direction to receive moves the host pointer to the end and sets not-ready.
  - A direction write that changes it to send zeroes the host pointer and clears not-ready.
  - A direction write that repeats the current direction changes nothing.
- R3: In send mode, each accepted host write stores its byte at the host pointer and advances the pointer. The write that stores the last byte sets not-ready and busy, visible one clock later.
- R4: The SCSI side handshakes only while the engine is armed and not-ready is 1. In send mode the data bus is driven (output enable 1) while ACK is high, and the bytes leave in the order the host wrote them.
- R5: When the last byte of a block completes its handshake, the engine does all of the following one clock later:
  - clears not-ready and busy;
  - zeroes both pointers;
  - decrements the block count modulo 256.
- R6: When the count decrements to 0, the engine:
  - disarms;
  - sets the end flag;
  - sets last-sent only in send mode;
  - sets the interrupt only if the interrupt-enable input is 1 at that moment.

  A count load clears all three flags.
- R7: In receive mode, the SCSI side writes each byte that arrives with REQ into the buffer, and a full buffer clears not-ready. The host then reads the bytes back in arrival order. The host read of the last byte sets not-ready again.
- R8: A host read returns 0xFF and leaves the pointer unchanged in either case:
  - the direction is send;
  - the host pointer is at the end.

  Host writes in receive mode are ignored.
- R9: A count load arms the engine, stores the count and clears busy. It also sets up the current direction: host pointer at the end and not-ready 1 for receive, host pointer 0 and not-ready 0 for send.
- R10: When the engine is armed, busy monitoring is enabled and the synchronized BSY is low, the engine disarms. After that, no ACK is produced for any REQ.
- R11: ACK rises three clocks after REQ rises, counting two synchronizer flops and the handshake state register. ACK falls three clocks after REQ falls, so ACK stays high for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host byte write strobe |
| host_wdata_i | input | 8 | Host write data |
| host_rd_i | input | 1 | Host byte read strobe; advances the host pointer |
| host_rdata_o | output | 8 | Byte returned for a host read this cycle (0xFF when not readable) |
| dir_wr_i | input | 1 | Direction write strobe |
| dir_i | input | 1 | Direction value (0 send, 1 receive) |
| cnt_ld_i | input | 1 | Block count load strobe |
| cnt_i | input | 8 | Block count value |
| eop_irq_en_i | input | 1 | Enables the interrupt at transfer end |
| bsy_mon_en_i | input | 1 | Enables abort when BSY is lost |
| dir_o | output | 1 | Current direction |
| not_ready_o | output | 1 | Buffer not-ready status |
| busy_o | output | 1 | Send block queued for the SCSI side |
| cnt_o | output | 8 | Remaining block count |
| armed_o | output | 1 | Count loaded, transfer in progress |
| eod_o | output | 1 | End-of-transfer flag |
| last_sent_o | output | 1 | Last byte sent flag (send only) |
| irq_o | output | 1 | Interrupt request |
| scsi_req_i | input | 1 | REQ from target (asynchronous) |
| scsi_bsy_i | input | 1 | BSY from bus (asynchronous) |
| scsi_data_i | input | 8 | Bus data in (receive) |
| scsi_data_o | output | 8 | Bus data out (send) |
| scsi_data_oe_o | output | 1 | Bus data output enable |
| scsi_ack_o | output | 1 | ACK to target |

## Verification
Host-side effects appear one clock after the strobe: pointer steps, not-ready and busy updates, count loads and direction changes. `host_rdata_o` is combinational and valid in the same cycle as the read strobe. SCSI-side effects are due three edges after a REQ or BSY change, because both synchronizer flops lie on the path. These effects are ACK rising, ACK falling, the block-end updates and disarming on a BSY loss.

The bench drives all inputs on the falling edge. A behavioural reference advances on the rising edge using the same sampled inputs, and the outputs are compared on every falling edge, half a cycle after the registers settle. On top of that running comparison, the bench measures the ACK latency and hold time as exact counts of edges, and it checks the whole byte sequence in both directions.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_ACK = 1'b1} seq_state_e;
  typedef enum logic {DIR_SEND = 1'b0, DIR_RECV = 1'b1} dir_e;
endpackage

// File: rtl/pdma_sync.sv
module pdma_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= '0;
      else         stg_q[g] <= (g == 0) ? d_i : stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pdma_buf.sv
module pdma_buf #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
  import pdma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic abort_i,
  input  logic req_s_i,
  output logic latch_o,
  output logic step_o,
  output logic ack_o
);
  seq_state_e state_q;

  assign latch_o = (state_q == SEQ_IDLE) && go_i && req_s_i && !abort_i;
  assign step_o  = (state_q == SEQ_ACK) && !req_s_i && !abort_i;
  assign ack_o   = (state_q == SEQ_ACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else if (state_q == SEQ_IDLE) begin
      if (latch_o) state_q <= SEQ_ACK;
    end else if (abort_i || !req_s_i) begin
      state_q <= SEQ_IDLE;
    end
  end

  // ACK only ever follows a seen REQ
  assert_ack_after_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(req_s_i));
  // abort drops ACK on the next edge
  assert_abort_drops_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !ack_o);
endmodule

// File: rtl/pdma_block_engine.sv
module pdma_block_engine
  import pdma_pkg::*;
#(
  parameter int BLK_BYTES   = 128,
  parameter int DW          = 8,
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PW = $clog2(BLK_BYTES + 1),
  localparam int AW = $clog2(BLK_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_wr_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          host_rd_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic          dir_wr_i,
  input  logic          dir_i,
  input  logic          cnt_ld_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          eop_irq_en_i,
  input  logic          bsy_mon_en_i,
  output logic          dir_o,
  output logic          not_ready_o,
  output logic          busy_o,
  output logic [CW-1:0] cnt_o,
  output logic          armed_o,
  output logic          eod_o,
  output logic          last_sent_o,
  output logic          irq_o,
  input  logic          scsi_req_i,
  input  logic          scsi_bsy_i,
  input  logic [DW-1:0] scsi_data_i,
  output logic [DW-1:0] scsi_data_o,
  output logic          scsi_data_oe_o,
  output logic          scsi_ack_o
);
  localparam logic [PW-1:0] PEND  = PW'(BLK_BYTES);
  localparam logic [PW-1:0] PLAST = PW'(BLK_BYTES - 1);

  dir_e          dir_q;
  logic [PW-1:0] hptr_q, sptr_q;
  logic          nr_q, busy_q, armed_q, eod_q, last_q, irq_q;
  logic [CW-1:0] cnt_q;

  logic          req_s, bsy_s, go, abort, latch, step;
  logic          wr_ok, rd_ok, buf_we;
  logic [AW-1:0] buf_waddr;
  logic [DW-1:0] buf_wdata, host_byte, scsi_byte;

  pdma_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({scsi_bsy_i, scsi_req_i}),
    .q_o ({bsy_s, req_s})
  );

  assign go    = armed_q && nr_q;
  assign abort = armed_q && bsy_mon_en_i && !bsy_s;

  pdma_seq u_seq (
    .clk_i, .rst_ni,
    .go_i    (go),
    .abort_i (abort),
    .req_s_i (req_s),
    .latch_o (latch),
    .step_o  (step),
    .ack_o   (scsi_ack_o)
  );

  assign wr_ok = host_wr_i && (dir_q == DIR_SEND) && (hptr_q < PEND);
  assign rd_ok = host_rd_i && (dir_q == DIR_RECV) && (hptr_q < PEND);

  assign buf_we    = wr_ok || (latch && dir_q == DIR_RECV);
  assign buf_waddr = (dir_q == DIR_RECV) ? sptr_q[AW-1:0] : hptr_q[AW-1:0];
  assign buf_wdata = (dir_q == DIR_RECV) ? scsi_data_i : host_wdata_i;

  pdma_buf #(.DEPTH(BLK_BYTES), .DW(DW)) u_buf (
    .clk_i,
    .we_i      (buf_we),
    .waddr_i   (buf_waddr),
    .wdata_i   (buf_wdata),
    .raddr_a_i (hptr_q[AW-1:0]),
    .rdata_a_o (host_byte),
    .raddr_b_i (sptr_q[AW-1:0]),
    .rdata_b_o (scsi_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= DIR_SEND;
      hptr_q  <= PEND;
      sptr_q  <= '0;
      nr_q    <= 1'b0;
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      eod_q   <= 1'b0;
      last_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else if (cnt_ld_i) begin
      cnt_q   <= cnt_i;
      armed_q <= 1'b1;
      sptr_q  <= '0;
      busy_q  <= 1'b0;
      eod_q   <= 1'b0;
      last_q  <= 1'b0;
      irq_q   <= 1'b0;
      hptr_q  <= (dir_q == DIR_RECV) ? PEND : '0;
      nr_q    <= (dir_q == DIR_RECV);
    end else if (dir_wr_i && (dir_e'(dir_i) != dir_q)) begin
      dir_q  <= dir_e'(dir_i);
      hptr_q <= dir_i ? PEND : '0;
      nr_q   <= dir_i;
    end else begin
      if (wr_ok || rd_ok) begin
        hptr_q <= hptr_q + PW'(1);
        if (hptr_q == PLAST) begin
          nr_q <= 1'b1;
          if (wr_ok) busy_q <= 1'b1;
        end
      end
      if (step) begin
        if (sptr_q == PLAST) begin
          sptr_q <= '0;
          hptr_q <= '0;
          nr_q   <= 1'b0;
          busy_q <= 1'b0;
          cnt_q  <= cnt_q - CW'(1);
          if (cnt_q == CW'(1)) begin
            armed_q <= 1'b0;
            eod_q   <= 1'b1;
            last_q  <= (dir_q == DIR_SEND);
            irq_q   <= eop_irq_en_i;
          end
        end else begin
          sptr_q <= sptr_q + PW'(1);
        end
      end
      if (abort) armed_q <= 1'b0;
    end
  end

  assign host_rdata_o   = ((dir_q == DIR_RECV) && (hptr_q < PEND)) ? host_byte : {DW{1'b1}};
  assign scsi_data_o    = scsi_byte;
  assign scsi_data_oe_o = armed_q && nr_q && (dir_q == DIR_SEND);
  assign dir_o          = dir_q;
  assign not_ready_o    = nr_q;
  assign busy_o         = busy_q;
  assign cnt_o          = cnt_q;
  assign armed_o        = armed_q;
  assign eod_o          = eod_q;
  assign last_sent_o    = last_q;
  assign irq_o          = irq_q;

  assert_hptr_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hptr_q <= PEND);
  assert_sptr_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sptr_q < PEND);
  // while ACK is high in send mode the byte must be on the bus
  assert_ack_with_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scsi_ack_o && dir_q == DIR_SEND) |-> scsi_data_oe_o);
  assert_irq_needs_eod_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> eod_q);
  assert_eod_at_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eod_q) |-> (cnt_q == '0 && !armed_q));
  assert_wr_only_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |-> !nr_q);
endmodule

// File: tb/sim_pdma_block_engine.sv
`timescale 1ns/1ps
module sim_pdma_block_engine;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_ni = 1'b0;
  logic       host_wr = 0, host_rd = 0, dir_wr = 0, dir_in = 0, cnt_ld = 0;
  logic [7:0] host_wdata = 0, cnt_in = 0, sdata_in = 0;
  logic       eop_en = 0, mon_en = 0, req = 0, bsy = 1;
  logic [7:0] host_rdata, cnt_o, data_o;
  logic       dir_o, nr_o, busy_o, armed_o, eod_o, last_o, irq_o, oe_o, ack_o;

  pdma_block_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_wr_i(host_wr), .host_wdata_i(host_wdata), .host_rd_i(host_rd), .host_rdata_o(host_rdata),
    .dir_wr_i(dir_wr), .dir_i(dir_in), .cnt_ld_i(cnt_ld), .cnt_i(cnt_in),
    .eop_irq_en_i(eop_en), .bsy_mon_en_i(mon_en),
    .dir_o(dir_o), .not_ready_o(nr_o), .busy_o(busy_o), .cnt_o(cnt_o), .armed_o(armed_o),
    .eod_o(eod_o), .last_sent_o(last_o), .irq_o(irq_o),
    .scsi_req_i(req), .scsi_bsy_i(bsy), .scsi_data_i(sdata_in),
    .scsi_data_o(data_o), .scsi_data_oe_o(oe_o), .scsi_ack_o(ack_o)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  bit         m_r1 = 0, m_r2 = 0, m_b1 = 0, m_b2 = 0, m_st = 0;
  bit         m_dir = 0, m_nr = 0, m_busy = 0, m_armed = 0, m_eod = 0, m_last = 0, m_irq = 0;
  int         m_hp = 128, m_sp = 0;
  logic [7:0] m_cnt = 0;
  logic [7:0] m_buf [128];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_r1 = 0; m_r2 = 0; m_b1 = 0; m_b2 = 0; m_st = 0;
      m_dir = 0; m_nr = 0; m_busy = 0; m_armed = 0; m_eod = 0; m_last = 0; m_irq = 0;
      m_hp = 128; m_sp = 0; m_cnt = 0;
    end else begin
      bit rs, bs, go, ab, step;
      rs = m_r2; bs = m_b2;
      m_r2 = m_r1; m_r1 = req; m_b2 = m_b1; m_b1 = bsy;
      go = m_armed && m_nr;
      ab = m_armed && mon_en && !bs;
      step = 0;
      if (m_st == 0) begin
        if (!ab && go && rs) begin
          if (m_dir) m_buf[m_sp] = sdata_in;
          m_st = 1;
        end
      end else if (ab) m_st = 0;
      else if (!rs) begin m_st = 0; step = 1; end
      if (cnt_ld) begin
        m_cnt = cnt_in; m_armed = 1; m_sp = 0; m_busy = 0;
        m_eod = 0; m_last = 0; m_irq = 0;
        m_hp = m_dir ? 128 : 0; m_nr = m_dir;
      end else if (dir_wr && dir_in != m_dir) begin
        m_dir = dir_in; m_hp = dir_in ? 128 : 0; m_nr = dir_in;
      end else begin
        if (host_wr && !m_dir && m_hp < 128) begin
          m_buf[m_hp] = host_wdata; m_hp++;
          if (m_hp == 128) begin m_nr = 1; m_busy = 1; end
        end
        if (host_rd && m_dir && m_hp < 128) begin
          m_hp++;
          if (m_hp == 128) m_nr = 1;
        end
        if (step) begin
          if (m_sp == 127) begin
            m_sp = 0; m_hp = 0; m_nr = 0; m_busy = 0;
            if (m_cnt == 1) begin
              m_armed = 0; m_eod = 1; m_last = !m_dir; m_irq = eop_en;
            end
            m_cnt = m_cnt - 8'd1;
          end else m_sp++;
        end
        if (ab) m_armed = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R2 dir", dir_o, m_dir);
      chk("R3 not_ready", nr_o, m_nr);
      chk("R5 busy", busy_o, m_busy);
      chk("R5 count", cnt_o, m_cnt);
      chk("R10 armed", armed_o, m_armed);
      chk("R6 eod", eod_o, m_eod);
      chk("R6 last_sent", last_o, m_last);
      chk("R6 irq", irq_o, m_irq);
      chk("R11 ack", ack_o, m_st);
      chk("R4 oe", oe_o, m_armed && m_nr && !m_dir);
      if (oe_o) chk("R4 data", data_o, m_buf[m_sp]);
      chk("R7 rdata", host_rdata, (m_dir && m_hp < 128) ? m_buf[m_hp] : 8'hFF);
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
      summary();
      $finish;
    end
  end

  logic [7:0] sent_q[$], exp_q[$];

  task automatic hwrite(input logic [7:0] d);
    host_wr = 1; host_wdata = d; @(negedge clk); host_wr = 0;
  endtask
  task automatic hread(output logic [7:0] d);
    host_rd = 1; #1 d = host_rdata; @(negedge clk); host_rd = 0;
  endtask
  task automatic ldcnt(input logic [7:0] c);
    cnt_ld = 1; cnt_in = c; @(negedge clk); cnt_ld = 0;
  endtask
  task automatic setdir(input logic d);
    dir_wr = 1; dir_in = d; @(negedge clk); dir_wr = 0;
  endtask
  task automatic tgt(input int n, input bit recv, input int seed, input bit chk_lat);
    for (int i = 0; i < n; i++) begin
      int lat, hold;
      if (recv) sdata_in = 8'(seed + i * 5);
      req = 1; lat = 0;
      do begin @(negedge clk); lat++; end while (!ack_o);
      if (chk_lat && i == 0) chk("R11 ack rise latency", lat, 3);
      if (!recv) begin
        chk("R4 oe during ack", oe_o, 1);
        sent_q.push_back(data_o);
      end
      req = 0; hold = 0;
      while (ack_o) begin @(negedge clk); hold++; end
      if (chk_lat && i == 0) chk("R11 ack fall latency", hold, 3);
    end
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R1 reset not_ready", nr_o, 0);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset count", cnt_o, 0);
    chk("R1 reset armed", armed_o, 0);
    chk("R1 reset eod", eod_o, 0);
    chk("R1 reset ack", ack_o, 0);
    chk("R1 reset rdata", host_rdata, 8'hFF);
    rst_ni = 1;
    repeat (3) @(negedge clk);

    hread(d); chk("R8 read in send", d, 8'hFF);
    hwrite(8'hAA);
    chk("R1 write dropped at end", nr_o, 0);

    // send two blocks
    eop_en = 1;
    ldcnt(8'd2);
    chk("R9 send setup not_ready", nr_o, 0);
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 128; i++) begin
        d = 8'(i * 3 + b * 7 + 1);
        hwrite(d); exp_q.push_back(d);
      end
      chk("R3 full not_ready", nr_o, 1);
      chk("R3 full busy", busy_o, 1);
      tgt(128, 0, 0, b == 0);
      repeat (2) @(negedge clk);
      chk("R5 block end not_ready", nr_o, 0);
      chk("R5 block end busy", busy_o, 0);
      chk("R5 count dec", cnt_o, 1 - b);
    end
    chk("R4 byte count", sent_q.size(), 256);
    for (int i = 0; i < 256; i++) chk("R4 byte order", sent_q[i], exp_q[i]);
    chk("R6 send eod", eod_o, 1);
    chk("R6 send last", last_o, 1);
    chk("R6 send irq", irq_o, 1);
    chk("R6 send disarmed", armed_o, 0);
    sent_q.delete(); exp_q.delete();

    // receive one block
    eop_en = 0;
    setdir(1);
    chk("R2 to recv not_ready", nr_o, 1);
    chk("R2 to recv rdata", host_rdata, 8'hFF);
    ldcnt(8'd1);
    chk("R9 recv setup not_ready", nr_o, 1);
    chk("R6 load clears eod", eod_o, 0);
    chk("R6 load clears irq", irq_o, 0);
    tgt(128, 1, 8'h20, 1);
    repeat (2) @(negedge clk);
    chk("R7 full clears not_ready", nr_o, 0);
    hwrite(8'h11);
    for (int i = 0; i < 128; i++) begin
      hread(d); chk("R7 read order", d, 8'(8'h20 + i * 5));
    end
    chk("R7 drained not_ready", nr_o, 1);
    hread(d); chk("R8 read past end", d, 8'hFF);
    chk("R6 recv eod", eod_o, 1);
    chk("R6 recv no last", last_o, 0);
    chk("R6 irq masked", irq_o, 0);
    setdir(1);
    chk("R2 same dir no change", nr_o, 1);
    setdir(0);
    chk("R2 to send not_ready", nr_o, 0);

    // abort on BSY loss
    mon_en = 1;
    ldcnt(8'd3);
    chk("R9 reload send not_ready", nr_o, 0);
    for (int i = 0; i < 128; i++) hwrite(8'(i));
    tgt(5, 0, 0, 0);
    bsy = 0;
    repeat (4) @(negedge clk);
    chk("R10 abort disarms", armed_o, 0);
    req = 1;
    begin
      int acks = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (ack_o) acks++; end
      chk("R10 no ack after abort", acks, 0);
    end
    chk("R10 no drive after abort", oe_o, 0);
    req = 0; bsy = 1; mon_en = 0;
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule